// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Encoded Acknowledge

This block sits between a set of device interrupt request lines and a processor. Each line carries a fixed priority number from 1 to `NUM_LINES`, and line 1 is the most important. The block raises a single pending flag toward the processor whenever some request outranks whatever is currently being serviced. When the processor signals that it is ready, the block picks the most important such request. On the next cycle it broadcasts the winner's number in binary on a shared acknowledge field, qualified by a one-cycle valid strobe. Each device compares the field against its own number to learn that it has been accepted.

Accepted levels are kept on a small stack of service levels. Only a request of strictly better priority than the top of that stack can be accepted, so handlers can nest while equal and lower requests keep waiting. An end-of-service pulse pops the stack and restores the previous masking level. Request lines are level-sensitive. A device holds its line until it sees its own number acknowledged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `ack_valid_o` is 0 and `ack_code_o` is 0. Reset empties the service stack, so after reset any request raises `irq_o`.
- R2: `irq_o` is 1 in the same cycle, combinationally, exactly when some active request has a number strictly smaller than the current service level. When nothing is in service, every active request counts.
- R3: Line k is `req_i[k-1]`. Among eligible requests, the lowest-numbered one wins.
- R4: When `cpu_ready_i` is 1 at a clock edge and an eligible request exists, `ack_valid_o` is 1 for the following cycle. In that cycle `ack_code_o` holds the winner's number as an unsigned binary value from 1 to `NUM_LINES`. Whenever `ack_valid_o` is 0, `ack_code_o` is 0.
- R5: No acknowledge is issued while `cpu_ready_i` is 0. A pending request keeps waiting and keeps `irq_o` high.
- R6: An acknowledged number becomes the current service level. Requests with an equal or larger number then neither raise `irq_o` nor get acknowledged.
- R7: A request with a strictly smaller number than the current service level is acknowledged on top of it (nesting), and its number becomes the new service level.
- R8: A 1 on `eoi_i` at a clock edge ends the innermost service level. The previous level, or the idle state, applies from the next cycle.
- R9: `eoi_i` while nothing is in service has no effect.
- R10: When `eoi_i` and an acknowledge fall on the same edge, arbitration uses the level in force before the end of service. The winner then replaces the ended level, so nesting depth is unchanged. If nothing outranks the old level, only the pop happens.
- R11: A request still held after its acknowledge is not acknowledged a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_LINES | Level request lines, bit k-1 is line k |
| cpu_ready_i | input | 1 | Processor can take an interrupt now |
| eoi_i | input | 1 | End of service for the innermost level |
| irq_o | output | 1 | A request outranks the current service level |
| ack_valid_o | output | 1 | Acknowledge strobe, one cycle per acceptance |
| ack_code_o | output | CODE_W | Binary number of the accepted line, 0 when idle |

## Verification
Ending a service level and accepting a new request can land on the same clock edge. Both the arbitration and the stack update then act on the same innermost level. The bench provokes this case twice. In one, a request outranks the level being ended, and the acknowledge must appear while the stack depth stays the same. In the other, the request only becomes eligible after the pop, so it must get no acknowledge that cycle and be accepted on the next ready cycle. The result in both cases is judged at the ports: from the acknowledge code, and from `irq_o` on the cycles that follow, which shows the masking level that is left in force.

// File: rtl/prio_irq_pkg.sv
// Package: shared types and helpers for the prioritized interrupt controller.
// Assumes level 0 encodes "nothing in service" and smaller numbers outrank.
package prio_irq_pkg;

    // Operation applied to the service-level stack on a clock edge.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    // True when candidate line number cand may preempt service level lvl.
    function automatic logic outranks(input int unsigned cand, input int unsigned lvl);
        return (lvl == 0) || (cand < lvl);
    endfunction

endpackage

// File: rtl/prio_irq_pick.sv
// Module: masked priority selector.
// Marks each request line that outranks the current service level, then
// returns the lowest-numbered such line as a binary code (1..N).
// Assumes bit k of req_i is line k+1; purely combinational.
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES = 7,
    parameter int CODE_W    = $clog2(NUM_LINES + 1)
) (
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [CODE_W-1:0]    level_i,
    output logic                 any_o,
    output logic [CODE_W-1:0]    win_code_o
);

    logic [NUM_LINES-1:0] elig;

    // Per-line eligibility against the current service level.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
        assign elig[g] = req_i[g] && outranks(g + 1, int'(level_i));
    end

    // Pending flag toward the processor.
    assign any_o = |elig;

    // Scan from the least to the most important line so the lowest number wins.
    always_comb begin
        win_code_o = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (elig[k]) begin
                win_code_o = CODE_W'(k + 1);
            end
        end
    end

endmodule

// File: rtl/prio_irq_stack.sv
// Module: stack of in-service levels.
// Push on an acceptance, pop on end of service, swap when both happen at
// once. The top entry is the current masking level; 0 when empty.
// Assumes the caller never pushes when full (strictly rising priority
// keeps the depth at or below the number of lines).
module prio_irq_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH  = 7,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] top_o,
    output logic              empty_o
);

    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CODE_W-1:0] mem_q [DEPTH];
    logic [SPW-1:0]    sp_q;
    logic [SPW-1:0]    sp_m1;
    logic [IW-1:0]     top_idx;
    logic [IW-1:0]     wr_idx;

    assign sp_m1   = sp_q - SPW'(1);
    assign top_idx = sp_m1[IW-1:0];
    assign wr_idx  = sp_q[IW-1:0];
    assign empty_o = (sp_q == '0);

    // Current masking level is the top entry, idle code when empty.
    assign top_o = empty_o ? '0 : mem_q[top_idx];

    // Apply the requested stack operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            case (op_i)
                STK_PUSH: begin
                    mem_q[wr_idx] <= code_i;
                    sp_q          <= sp_q + SPW'(1);
                end
                STK_POP: begin
                    sp_q <= sp_m1;
                end
                STK_SWAP: begin
                    mem_q[top_idx] <= code_i;
                end
                default: begin
                end
            endcase
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH) |-> (sp_q < SPW'(DEPTH)));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_POP || op_i == STK_SWAP) |-> !empty_o);

    // R6
    push_lands_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH) |=> (top_o == $past(code_i)));

    // R8
    pop_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_POP) |=> (sp_q == $past(sp_q) - SPW'(1)));

endmodule

// File: rtl/prio_irq_ack.sv
// Module: acknowledge register.
// Turns an acceptance decision into a one-cycle valid strobe plus the
// binary code of the winner; the code reads 0 whenever the strobe is low.
module prio_irq_ack #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ack_valid_o,
    output logic [CODE_W-1:0] ack_code_o
);

    // Register the strobe and gate the code with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid_o <= 1'b0;
            ack_code_o  <= '0;
        end else begin
            ack_valid_o <= fire_i;
            ack_code_o  <= fire_i ? code_i : '0;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prioritized interrupt controller, top level.
// Flags pending requests that outrank the current service level, accepts
// the best one when the processor is ready, broadcasts its number on the
// acknowledge field and tracks nested service levels on a stack.
// Assumes level-sensitive requests held until acknowledged.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES = 7,
    localparam int CODE_W   = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 cpu_ready_i,
    input  logic                 eoi_i,
    output logic                 irq_o,
    output logic                 ack_valid_o,
    output logic [CODE_W-1:0]    ack_code_o
);

    logic [CODE_W-1:0] level;
    logic              stk_empty;
    logic              any_elig;
    logic [CODE_W-1:0] win_code;
    logic              fire;
    logic              end_svc;
    stk_op_e           stk_op;

    prio_irq_pick #(
        .NUM_LINES (NUM_LINES),
        .CODE_W    (CODE_W)
    ) u_pick (
        .req_i      (req_i),
        .level_i    (level),
        .any_o      (any_elig),
        .win_code_o (win_code)
    );

    prio_irq_stack #(
        .DEPTH  (NUM_LINES),
        .CODE_W (CODE_W)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (stk_op),
        .code_i  (win_code),
        .top_o   (level),
        .empty_o (stk_empty)
    );

    prio_irq_ack #(
        .CODE_W (CODE_W)
    ) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .code_i      (win_code),
        .ack_valid_o (ack_valid_o),
        .ack_code_o  (ack_code_o)
    );

    assign irq_o   = any_elig;
    assign fire    = cpu_ready_i && any_elig;
    assign end_svc = eoi_i && !stk_empty;

    // Choose the stack update from acceptance and end of service.
    always_comb begin
        unique case ({fire, end_svc})
            2'b11:   stk_op = STK_SWAP;
            2'b10:   stk_op = STK_PUSH;
            2'b01:   stk_op = STK_POP;
            default: stk_op = STK_HOLD;
        endcase
    end

    // R4
    ack_code_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> (ack_code_o != '0));

    // R4
    ack_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid_o |-> (ack_code_o == '0));

    // R5
    ack_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(cpu_ready_i));

    // R3
    ack_req_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> ((($past(req_i) >> (ack_code_o - 1'b1)) & NUM_LINES'(1)) != '0));

    // R6
    ack_sets_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> (level == ack_code_o));

    // R11
    no_repeat_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |=> (!ack_valid_o || (ack_code_o < $past(ack_code_o))));

    // R2
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> !irq_o);

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    localparam int N  = 7;
    localparam int CW = 3;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic          cpu_ready_i = 1'b0;
    logic          eoi_i = 1'b0;
    logic          irq_o;
    logic          ack_valid_o;
    logic [CW-1:0] ack_code_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NUM_LINES(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .cpu_ready_i (cpu_ready_i),
        .eoi_i       (eoi_i),
        .irq_o       (irq_o),
        .ack_valid_o (ack_valid_o),
        .ack_code_o  (ack_code_o)
    );

    // Vector: {req[6:0], ready, eoi, exp_irq, exp_ack_valid, exp_code[2:0]}
    localparam logic [13:0] VEC [NV] = '{
        {7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        {7'b0010100, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {7'b0010100, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3},
        {7'b0010000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {7'b0010100, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {7'b0010001, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {7'b0010001, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1},
        {7'b0010010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {7'b0010010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {7'b0010010, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {7'b0010010, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2},
        {7'b0010000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {7'b0010000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
        {7'b0000000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {7'b1000000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7},
        {7'b0000000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},
        {7'b1111111, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1},
        {7'b0001000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
        {7'b0001000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4},
        {7'b0000000, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}
    };

    string vtag [NV] = '{"R1", "R5", "R3", "R6", "R11", "R2", "R7", "R6", "R8", "R8",
                         "R10", "R8", "R8", "R9", "R9", "R8", "R3", "R10", "R4", "R8"};

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Drive at the falling edge, check irq just after, check the acknowledge after the rising edge.
    task automatic step(input string tag, input logic [N-1:0] rq, input logic rdy, input logic eo,
                        input logic e_irq, input logic e_av, input int e_code);
        @(negedge clk);
        req_i = rq;
        cpu_ready_i = rdy;
        eoi_i = eo;
        #1;
        check(tag, "irq_o", int'(irq_o), int'(e_irq));
        @(posedge clk);
        #1;
        check(tag, "ack_valid_o", int'(ack_valid_o), int'(e_av));
        check(tag, "ack_code_o", int'(ack_code_o), e_code);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: outputs held at zero through reset
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ack_valid_o in reset", int'(ack_valid_o), 0);
        check("R1", "ack_code_o in reset", int'(ack_code_o), 0);
        check("R1", "irq_o in reset", int'(irq_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(vtag[i], VEC[i][13:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], int'(VEC[i][2:0]));
        end

        // R1: reset in the middle of service clears the level
        step("R1", 7'b0000010, 1'b1, 1'b0, 1'b1, 1'b1, 2);
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '0;
        cpu_ready_i = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "ack_valid_o after mid reset", int'(ack_valid_o), 0);
        check("R1", "ack_code_o after mid reset", int'(ack_code_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 7'b0010000, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        step("R1", 7'b0010000, 1'b1, 1'b0, 1'b1, 1'b1, 5);
        // R11: ready held with request held gives no second acknowledge
        step("R11", 7'b0010000, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        step("R8", 7'b0000000, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        done = 1'b1;
        finish_run();
    end

endmodule